// File: doc/BRIEF.md
# Time-Triggered CAN Local Timer

This block keeps the 16-bit local time of a time-triggered CAN controller. An internal prescaler divides the system clock by a programmable 8-bit value, and each prescaler tick advances the local time by one. The count either runs freely, wrapping through zero, or returns to zero after it reaches a compare value, which gives a repeating basic cycle.

Software sees two 16-bit registers through a small register port. One holds the local time. It can be overwritten, but only while the timer is enabled and the controller is in event-triggered mode. The other is a read-only cycle time, equal to local time minus a reference mark. In event-triggered mode the mark counts as zero, so cycle time equals local time. Capturing the reference mark from frames and all other controller functions belong to neighbouring blocks.

Top module: `ttcan_local_timer`

## Requirements
- R1: After reset, local time, cycle time and both register reads are 0x0000.
- R2: While tmr_en_i is 0, local time reads 0x0000 at all times, and the stored count and prescaler return to zero.
- R3: While enabled, local time rises by one on each prescaler tick, and a tick occurs once every presc_div_i+1 clock cycles.
- R4: With cmp_clr_en_i at 0, local time wraps from 0xFFFF to 0x0000 and keeps counting.
- R5: With cmp_clr_en_i at 1, a tick that finds local time equal to cmp_val_i sets it to 0x0000, and counting continues from there.
- R6: A write (reg_wr_i=1) to offset 0x08C loads reg_wdata_i into local time on the next clock edge when tmr_en_i is 1 and mode_i is 3'b111 (event-triggered).
- R7: A write to offset 0x08C while disabled or with mode_i other than 3'b111 is ignored. A write to offset 0x090 or to any other offset is ignored. In all these cases local time follows the tick count alone.
- R8: When an allowed write falls in the same cycle as a tick, including a tick that would compare-clear, the written value wins.
- R9: With mode_i other than 3'b111, cycle time equals local time minus ref_mark_i, modulo 2^16.
- R10: With mode_i equal to 3'b111, cycle time equals local time, whatever ref_mark_i holds.
- R11: After tmr_en_i rises, the prescaler starts again from zero, so the first tick comes presc_div_i+1 clock cycles after the first enabled cycle.
- R12: Reading offset 0x08C returns local time, offset 0x090 returns cycle time, and any other offset returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_en_i | input | 1 | Timer enable |
| cmp_clr_en_i | input | 1 | Clear local time on compare match |
| mode_i | input | 3 | Cycle-max mode field; 3'b111 selects event-triggered mode |
| cmp_val_i | input | 16 | Compare value for the cycle clear |
| ref_mark_i | input | 16 | Reference mark subtracted to form cycle time |
| presc_div_i | input | 8 | Prescaler divide value (tick every value+1 clocks) |
| reg_addr_i | input | 12 | Register offset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from reg_addr_i |
| local_time_o | output | 16 | Current local time |
| cycle_time_o | output | 16 | Current cycle time |

## Verification
The case that needs care is a software write arriving in the same cycle as a prescaler tick that would also clear the count on a compare match. The bench sets the divide value to zero so that every cycle ticks, lets the count run up to the compare value, and asserts the write in that same cycle. The count after the edge must be the written value, not zero and not the compare value plus one. A second case drives the write together with the enable rise, where the first tick would also fall, and expects the written value there too.

// File: rtl/ttcan_lt_pkg.sv
package ttcan_lt_pkg;
  localparam int unsigned LT_W      = 16;
  localparam int unsigned DIV_W     = 8;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned MODE_W    = 3;
  localparam logic [ADDR_W-1:0] LT_OFS = 12'h08C;
  localparam logic [ADDR_W-1:0] CT_OFS = 12'h090;
  localparam logic [MODE_W-1:0] ET_MODE = 3'b111;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_LT,
    SEL_CT
  } reg_sel_e;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_ZERO,
    ACT_LOAD,
    ACT_STEP,
    ACT_WRAPCLR
  } cnt_act_e;
endpackage

// File: rtl/ttcan_lt_presc.sv
module ttcan_lt_presc #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic             at_end;

  // >= keeps a shrinking divide value from forcing a full 2^DIV_W lap
  assign at_end = (pre_q >= div_i);
  assign tick_o = en_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (!en_i || at_end) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/ttcan_lt_counter.sv
module ttcan_lt_counter
  import ttcan_lt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic             clr_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  cnt_act_e         act;

  // priority: disable, software load, compare clear, step
  always_comb begin
    act = ACT_HOLD;
    if (!en_i) begin
      act = ACT_ZERO;
    end else if (load_i) begin
      act = ACT_LOAD;
    end else if (tick_i) begin
      if (clr_en_i && (cnt_q == cmp_i)) act = ACT_WRAPCLR;
      else                              act = ACT_STEP;
    end
  end

  always_comb begin
    unique case (act)
      ACT_ZERO,
      ACT_WRAPCLR: cnt_d = '0;
      ACT_LOAD:    cnt_d = load_val_i;
      ACT_STEP:    cnt_d = cnt_q + 1'b1;
      default:     cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ttcan_lt_regif.sv
module ttcan_lt_regif
  import ttcan_lt_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned MODE_W = 3,
  parameter logic [ADDR_W-1:0] LT_ADDR = 12'h08C,
  parameter logic [ADDR_W-1:0] CT_ADDR = 12'h090,
  parameter logic [MODE_W-1:0] ET_CODE = 3'b111
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  ref_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [CNT_W-1:0]  local_o,
  output logic [CNT_W-1:0]  cycle_o
);
  reg_sel_e         sel;
  logic             et_mode;
  logic [CNT_W-1:0] ref_eff;

  always_comb begin
    if (addr_i == LT_ADDR)      sel = SEL_LT;
    else if (addr_i == CT_ADDR) sel = SEL_CT;
    else                        sel = SEL_NONE;
  end

  assign et_mode = (mode_i == ET_CODE);
  // cycle-time offset is read only; only the local-time offset accepts a write
  assign load_o  = wr_i & (sel == SEL_LT) & en_i & et_mode;

  assign local_o = en_i ? cnt_i : '0;
  assign ref_eff = et_mode ? '0 : ref_i;
  assign cycle_o = local_o - ref_eff;

  always_comb begin
    unique case (sel)
      SEL_LT:  rdata_o = local_o;
      SEL_CT:  rdata_o = cycle_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ttcan_local_timer.sv
module ttcan_local_timer
  import ttcan_lt_pkg::*;
#(
  parameter int unsigned CNT_W  = LT_W,
  parameter int unsigned PDIV_W = DIV_W,
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned MW     = MODE_W,
  parameter logic [AW-1:0] LT_ADDR = LT_OFS,
  parameter logic [AW-1:0] CT_ADDR = CT_OFS,
  parameter logic [MW-1:0] ET_CODE = ET_MODE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_en_i,
  input  logic              cmp_clr_en_i,
  input  logic [MW-1:0]     mode_i,
  input  logic [CNT_W-1:0]  cmp_val_i,
  input  logic [CNT_W-1:0]  ref_mark_i,
  input  logic [PDIV_W-1:0] presc_div_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic [CNT_W-1:0]  local_time_o,
  output logic [CNT_W-1:0]  cycle_time_o
);
  logic             presc_tick;
  logic             sw_load;
  logic [CNT_W-1:0] cnt_q;

  ttcan_lt_presc #(.DIV_W(PDIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tmr_en_i),
    .div_i  (presc_div_i),
    .tick_o (presc_tick)
  );

  ttcan_lt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (tmr_en_i),
    .load_i     (sw_load),
    .load_val_i (reg_wdata_i),
    .tick_i     (presc_tick),
    .clr_en_i   (cmp_clr_en_i),
    .cmp_i      (cmp_val_i),
    .cnt_o      (cnt_q)
  );

  ttcan_lt_regif #(
    .CNT_W   (CNT_W),
    .ADDR_W  (AW),
    .MODE_W  (MW),
    .LT_ADDR (LT_ADDR),
    .CT_ADDR (CT_ADDR),
    .ET_CODE (ET_CODE)
  ) u_regif (
    .addr_i  (reg_addr_i),
    .wr_i    (reg_wr_i),
    .mode_i  (mode_i),
    .en_i    (tmr_en_i),
    .cnt_i   (cnt_q),
    .ref_i   (ref_mark_i),
    .load_o  (sw_load),
    .rdata_o (reg_rdata_o),
    .local_o (local_time_o),
    .cycle_o (cycle_time_o)
  );
endmodule

// File: rtl/ttcan_local_timer_chk.sv
module ttcan_local_timer_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PDIV_W = 8,
  parameter int unsigned AW     = 12,
  parameter int unsigned MW     = 3,
  parameter logic [AW-1:0] LT_ADDR = 12'h08C,
  parameter logic [MW-1:0] ET_CODE = 3'b111
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              clr_en_i,
  input logic [MW-1:0]     mode_i,
  input logic [CNT_W-1:0]  cmp_i,
  input logic [PDIV_W-1:0] div_i,
  input logic [AW-1:0]     addr_i,
  input logic              wr_i,
  input logic [CNT_W-1:0]  wdata_i,
  input logic              tick_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  local_i,
  input logic [CNT_W-1:0]  cycle_i
);
  logic             wr_ok;
  logic             hit;
  logic [CNT_W-1:0] cnt_inc;

  assign wr_ok   = wr_i && (addr_i == LT_ADDR) && en_i && (mode_i == ET_CODE);
  assign hit     = clr_en_i && (cnt_i == cmp_i);
  assign cnt_inc = cnt_i + 1'b1;

  AST_DISABLED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0)); // R2
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_ok && !hit) |=> (cnt_i == $past(cnt_inc))); // R3
  AST_CMP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_ok && hit) |=> (cnt_i == '0)); // R5
  AST_SW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok |=> (cnt_i == $past(wdata_i))); // R6
  AST_NO_STRAY_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i && !wr_ok) |=> $stable(cnt_i)); // R7
  AST_LOAD_OVER_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && tick_i && hit) |=> (cnt_i == $past(wdata_i))); // R8
  AST_ET_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == ET_CODE) |-> (cycle_i == local_i)); // R10
  AST_PRESC_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en_i) && (div_i != '0)) |-> !tick_i); // R11
endmodule

bind ttcan_local_timer ttcan_local_timer_chk #(
  .CNT_W   (CNT_W),
  .PDIV_W  (PDIV_W),
  .AW      (AW),
  .MW      (MW),
  .LT_ADDR (LT_ADDR),
  .ET_CODE (ET_CODE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (tmr_en_i),
  .clr_en_i (cmp_clr_en_i),
  .mode_i   (mode_i),
  .cmp_i    (cmp_val_i),
  .div_i    (presc_div_i),
  .addr_i   (reg_addr_i),
  .wr_i     (reg_wr_i),
  .wdata_i  (reg_wdata_i),
  .tick_i   (presc_tick),
  .cnt_i    (cnt_q),
  .local_i  (local_time_o),
  .cycle_i  (cycle_time_o)
);

// File: tb/ttcan_local_timer_test.sv
`timescale 1ns/1ps
module ttcan_local_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        clr = 1'b0;
  logic [2:0]  mode = 3'b111;
  logic [15:0] cmp = 16'h0;
  logic [15:0] refm = 16'h0;
  logic [7:0]  div = 8'h0;
  logic [11:0] addr = 12'h08C;
  logic        wr = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata, lt, ct;

  int checks = 0;
  int fails = 0;
  logic [15:0] tmp;

  always #2 clk = ~clk;

  ttcan_local_timer uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tmr_en_i     (en),
    .cmp_clr_en_i (clr),
    .mode_i       (mode),
    .cmp_val_i    (cmp),
    .ref_mark_i   (refm),
    .presc_div_i  (div),
    .reg_addr_i   (addr),
    .reg_wr_i     (wr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .local_time_o (lt),
    .cycle_time_o (ct)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance n rising edges, return at the following falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 local", lt, 16'h0);
    chk("R1 cycle", ct, 16'h0);
    addr = 12'h08C; #1;
    chk("R1 read lt", rdata, 16'h0);
    addr = 12'h090; #1;
    chk("R1 read ct", rdata, 16'h0);
  endtask

  task automatic t_disabled();
    en = 1'b0; div = 8'd0; mode = 3'b111;
    addr = 12'h08C; wr = 1'b1; wdata = 16'h5A5A;
    step(1);
    wr = 1'b0;
    chk("R7 write while disabled", lt, 16'h0);
    step(4);
    chk("R2 disabled local", lt, 16'h0);
    #1 chk("R2 disabled read", rdata, 16'h0);
  endtask

  task automatic t_count();
    en = 1'b1; div = 8'd3; clr = 1'b0; mode = 3'b111;
    step(3);
    chk("R11 no tick before div+1", lt, 16'h0);
    step(1);
    chk("R11 first tick", lt, 16'h1);
    step(8);
    chk("R3 one per div+1", lt, 16'h3);
    en = 1'b0;
    step(1);
    chk("R2 disable clears", lt, 16'h0);
    step(2);
    en = 1'b1;
    step(3);
    chk("R11 restart after re-enable", lt, 16'h0);
    step(1);
    chk("R2 count restarts at zero", lt, 16'h1);
  endtask

  task automatic t_wrap();
    en = 1'b0;
    step(1);
    en = 1'b1; div = 8'd0; mode = 3'b111; clr = 1'b0;
    addr = 12'h08C; wr = 1'b1; wdata = 16'hFFFE;
    step(1);
    wr = 1'b0;
    chk("R6/R8 load on enable edge", lt, 16'hFFFE);
    step(1);
    chk("R3 step", lt, 16'hFFFF);
    step(1);
    chk("R4 wrap to zero", lt, 16'h0000);
    step(1);
    chk("R4 continue after wrap", lt, 16'h0001);
  endtask

  task automatic t_clear();
    cmp = 16'd5; clr = 1'b1;
    wr = 1'b1; wdata = 16'h0;
    step(1);
    wr = 1'b0;
    step(5);
    chk("R5 reach compare", lt, 16'd5);
    step(1);
    chk("R5 compare clear", lt, 16'd0);
    step(3);
    chk("R5 counts on after clear", lt, 16'd3);
  endtask

  task automatic t_prio();
    step(2);
    chk("R5 at compare again", lt, 16'd5);
    wr = 1'b1; wdata = 16'h1234;
    step(1);
    wr = 1'b0;
    chk("R8 write beats compare clear", lt, 16'h1234);
  endtask

  task automatic t_blocked();
    clr = 1'b0;
    mode = 3'b001; addr = 12'h08C; wr = 1'b1; wdata = 16'h0AAA;
    step(1);
    chk("R7 write outside event mode", lt, 16'h1235);
    mode = 3'b111; addr = 12'h090; wdata = 16'h0BBB;
    step(1);
    chk("R7 write to cycle offset", lt, 16'h1236);
    addr = 12'h094; wdata = 16'h0CCC;
    step(1);
    wr = 1'b0;
    chk("R7 write to other offset", lt, 16'h1237);
  endtask

  task automatic t_cycle();
    div = 8'd200;
    mode = 3'b001; refm = 16'h2000;
    step(1);
    tmp = lt - 16'h2000;
    chk("R9 cycle = local - mark", ct, tmp);
    addr = 12'h090; #1;
    chk("R12 read cycle offset", rdata, tmp);
    addr = 12'h08C; #1;
    chk("R12 read local offset", rdata, lt);
    addr = 12'h0A0; #1;
    chk("R12 read other offset", rdata, 16'h0);
    refm = 16'hFFFF; #1;
    tmp = lt + 16'h0001;
    chk("R9 modulo subtraction", ct, tmp);
    mode = 3'b111; #1;
    chk("R10 event mode copy", ct, lt);
    addr = 12'h090; #1;
    chk("R10 read cycle in event mode", rdata, lt);
  endtask

  initial begin
    fork
      begin
        step(3);
        t_reset();
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_count();
        t_wrap();
        t_clear();
        t_prio();
        t_blocked();
        t_cycle();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule